// File: doc/BRIEF.md
# Stimulus Vector Sequencer

This block plays a stored stimulus program onto an output vector bus, one entry per clock. The program sits in an internal vector store. It has two regions. A one-shot preamble occupies the addresses below a configurable main-region start. The main region follows and runs up to a configurable last address. Every entry carries a 2-bit kind field. A data entry updates the output bus. A send-arm entry pulses a one-cycle arm output that can start external measurement equipment. A wait entry stalls the program until either a level-sensed 3-bit event input satisfies one of four configurable conditions, or the arm input is high.

Loops and subroutines are expanded before the program is loaded, so the engine only ever walks addresses in a straight line. In repetitive mode, after the last address the engine resumes at the main-region start, so the preamble plays only once after each start. In single-run mode it stops after the last address and raises done. A stop input returns it to idle from any state.

Top module: `stim_vec_seq`

## Requirements
- R1: After a synchronous active-low reset, vec_out is zero and arm_out, running and done are all low.
- R2: A start pulse seen while idle or done sets running on the next clock edge with the program address at 0. The entry at address 0 executes on the edge after that.
- R3: A data entry (kind 2'b00, bits [49:48]) loads its bits [47:0] onto vec_out at the edge where it executes. The address then advances by one, so one entry is consumed per clock. vec_out changes at no other time.
- R4: A send-arm entry (kind 2'b10) drives arm_out high for the single cycle after it executes. It leaves vec_out unchanged and advances the address.
- R5: An event-wait entry (kind 2'b01) uses bits [1:0] as a condition index c. It advances only in a cycle where bit (c*8 + ev_in) of cond_mask is 1. Until then, vec_out and the address hold.
- R6: An arm-wait entry (kind 2'b11) advances only in a cycle where arm_in is high. Until then, vec_out and the address hold.
- R7: In repetitive mode (repeat_en high), executing the entry at last_addr moves the address to main_start. Entries below main_start are not replayed, and running stays high.
- R8: In single-run mode (repeat_en low), executing the entry at last_addr drops running and raises done on the same edge. vec_out keeps its last value.
- R9: stop returns the engine to idle on the next edge from any state, with running and done low and vec_out held. stop wins over a simultaneous start.
- R10: start pulses while running have no effect on the program position.
- R11: A start pulse while done clears done and replays the program from address 0, preamble included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Vector clock; one entry per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the vector store |
| wr_addr | input | 6 | Store address to write |
| wr_data | input | 50 | Entry: kind in [49:48], payload in [47:0] |
| cond_mask | input | 32 | Four 8-bit event masks; condition c occupies bits c*8+7..c*8 |
| main_start | input | 6 | First address of the repeating main region |
| last_addr | input | 6 | Last address of the program |
| repeat_en | input | 1 | High: repeat main region; low: single run |
| start | input | 1 | Begin the program from address 0 |
| stop | input | 1 | Abort to idle |
| ev_in | input | 3 | Level-sensed external event value |
| arm_in | input | 1 | Arm input for arm-wait entries |
| vec_out | output | 48 | Current stimulus vector |
| arm_out | output | 1 | One-cycle arm pulse |
| running | output | 1 | Program is executing |
| done | output | 1 | Single run completed |

## Verification
The bench stalls the program at an event wait with event values that the mask rejects, including a value next to the accepted one. A design that indexed the mask wrongly or sampled the wrong condition would slip past the wait and show the next vector early. It then parks the program at an arm wait. A design that advanced there would reach done without an arm_in pulse. In repetitive mode it counts arm pulses across several passes of the main region. A design that wrapped to address 0, or that restarted on a start pulse received while running, would emit the preamble arm again. Stop with a simultaneous start and restart from done are also checked. A design that let start win, or that kept done across a restart, would diverge from the cycle model.

// File: rtl/stim_seq_pkg.sv
// Shared types for the stimulus vector sequencer.
// Assumes a 2-bit kind field at the top of every stored entry.
package stim_seq_pkg;

    typedef enum logic [1:0] {
        KIND_DATA     = 2'b00,
        KIND_WAIT_EV  = 2'b01,
        KIND_SEND_ARM = 2'b10,
        KIND_WAIT_ARM = 2'b11
    } entry_kind_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'b00,
        SQ_RUN  = 2'b01,
        SQ_DONE = 2'b10
    } seq_state_e;

endpackage

// File: rtl/stim_vec_store.sv
// Vector store: single write port, asynchronous read port.
// Assumes the store is written only while the engine is idle; contents are not reset.
module stim_vec_store #(
    parameter int EW    = 50,
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [EW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [EW-1:0] rd_data
);
    logic [EW-1:0] mem [DEPTH];

    // Store one entry per write strobe.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Present the entry at the current program address.
    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/stim_event_match.sv
// Evaluates the release condition of a wait entry.
// Each of NCOND conditions is a mask over all 2**EVW event values; the event is level-sensed.
module stim_event_match #(
    parameter int NCOND = 4,
    parameter int EVW   = 3,
    parameter int CIW   = $clog2(NCOND),
    parameter int NV    = 1 << EVW
) (
    input  logic [NCOND*NV-1:0] cond_mask,
    input  logic [EVW-1:0]      ev_in,
    input  logic                arm_in,
    input  logic [CIW-1:0]      cond_sel,
    input  logic                use_arm,
    output logic                cond_ok
);
    logic [NCOND-1:0] hit;

    // One lookup per condition: is the present event value in its mask.
    for (genvar g = 0; g < NCOND; g++) begin : g_cond
        logic [NV-1:0] m;
        assign m      = cond_mask[g*NV +: NV];
        assign hit[g] = m[ev_in];
    end

    // Pick the arm input or the selected condition.
    always_comb begin
        cond_ok = use_arm ? arm_in : hit[cond_sel];
    end
endmodule

// File: rtl/stim_seq_ctrl.sv
// Program sequencer: walks the store address, applies data entries, issues arm pulses,
// and stalls on wait entries. Assumes main_start <= last_addr.
module stim_seq_ctrl
    import stim_seq_pkg::*;
#(
    parameter int VW = 48,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  entry_kind_e   kind,
    input  logic [VW-1:0] payload,
    input  logic          cond_ok,
    input  logic          start,
    input  logic          stop,
    input  logic          repeat_en,
    input  logic [AW-1:0] main_start,
    input  logic [AW-1:0] last_addr,
    output logic [AW-1:0] rd_addr,
    output logic [VW-1:0] vec_out,
    output logic          arm_out,
    output logic          running,
    output logic          done
);
    seq_state_e state;
    logic       step;
    logic       is_wait;
    logic       at_end;

    // Decide whether the current entry lets the program move on.
    always_comb begin
        is_wait = (kind == KIND_WAIT_EV) || (kind == KIND_WAIT_ARM);
        step    = !is_wait || cond_ok;
        at_end  = (rd_addr == last_addr);
    end

    // State, address, output vector and arm pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SQ_IDLE;
            rd_addr <= '0;
            vec_out <= '0;
            arm_out <= 1'b0;
        end else begin
            arm_out <= 1'b0;
            if (stop) begin
                state <= SQ_IDLE;
            end else begin
                case (state)
                    SQ_IDLE, SQ_DONE: begin
                        if (start) begin
                            state   <= SQ_RUN;
                            rd_addr <= '0;
                        end
                    end
                    SQ_RUN: begin
                        if (kind == KIND_DATA)     vec_out <= payload;
                        if (kind == KIND_SEND_ARM) arm_out <= 1'b1;
                        if (step) begin
                            if (at_end) begin
                                if (repeat_en) rd_addr <= main_start;
                                else           state   <= SQ_DONE;
                            end else begin
                                rd_addr <= rd_addr + 1'b1;
                            end
                        end
                    end
                    default: state <= SQ_IDLE;
                endcase
            end
        end
    end

    assign running = (state == SQ_RUN);
    assign done    = (state == SQ_DONE);

    // R9
    stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!running && !done));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> $stable(vec_out));

    // R5
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !stop && is_wait && !cond_ok) |=>
            ($stable(vec_out) && $stable(rd_addr) && running));

    // R4
    arm_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm_out |-> ($past(running) && $past(kind == KIND_SEND_ARM)));

    // R7
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !stop && step && at_end && repeat_en) |=>
            (running && rd_addr == $past(main_start)));

    // R8
    single_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !stop && step && at_end && !repeat_en) |=> (done && !running));

    // R2
    begin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> (rd_addr == '0));
endmodule

// File: rtl/stim_vec_seq.sv
// Top of the stimulus vector sequencer: store, wait-condition evaluator and sequencer.
// Entry layout: kind in the top two bits, payload below; wait entries use the low
// payload bits as the condition index.
module stim_vec_seq
    import stim_seq_pkg::*;
#(
    parameter int VW    = 48,
    parameter int DEPTH = 64,
    parameter int NCOND = 4,
    parameter int EVW   = 3,
    localparam int AW   = $clog2(DEPTH),
    localparam int EW   = VW + 2,
    localparam int CIW  = $clog2(NCOND),
    localparam int NV   = 1 << EVW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [EW-1:0]       wr_data,
    input  logic [NCOND*NV-1:0] cond_mask,
    input  logic [AW-1:0]       main_start,
    input  logic [AW-1:0]       last_addr,
    input  logic                repeat_en,
    input  logic                start,
    input  logic                stop,
    input  logic [EVW-1:0]      ev_in,
    input  logic                arm_in,
    output logic [VW-1:0]       vec_out,
    output logic                arm_out,
    output logic                running,
    output logic                done
);
    logic [AW-1:0] rd_addr;
    logic [EW-1:0] entry;
    entry_kind_e   kind;
    logic          cond_ok;

    stim_vec_store #(.EW(EW), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (entry)
    );

    // Split the entry into its kind field.
    assign kind = entry_kind_e'(entry[EW-1 -: 2]);

    stim_event_match #(.NCOND(NCOND), .EVW(EVW), .CIW(CIW), .NV(NV)) u_match (
        .cond_mask (cond_mask),
        .ev_in     (ev_in),
        .arm_in    (arm_in),
        .cond_sel  (entry[CIW-1:0]),
        .use_arm   (kind == KIND_WAIT_ARM),
        .cond_ok   (cond_ok)
    );

    stim_seq_ctrl #(.VW(VW), .AW(AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .kind       (kind),
        .payload    (entry[VW-1:0]),
        .cond_ok    (cond_ok),
        .start      (start),
        .stop       (stop),
        .repeat_en  (repeat_en),
        .main_start (main_start),
        .last_addr  (last_addr),
        .rd_addr    (rd_addr),
        .vec_out    (vec_out),
        .arm_out    (arm_out),
        .running    (running),
        .done       (done)
    );
endmodule

// File: tb/tb_stim_vec_seq.sv
module tb_stim_vec_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [49:0] wr_data = '0;
    logic [31:0] cond_mask = '0;
    logic [5:0]  main_start = '0;
    logic [5:0]  last_addr = '0;
    logic        repeat_en = 1'b0;
    logic        start = 1'b0;
    logic        stop = 1'b0;
    logic [2:0]  ev_in = '0;
    logic        arm_in = 1'b0;
    logic [47:0] vec_out;
    logic        arm_out, running, done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int arm_cnt = 0;
    string cur_tag = "R1";

    // Behavioural reference state
    logic [49:0] mm [64];
    int          m_addr = 0;
    logic [47:0] m_vec = '0;
    bit          m_arm = 0, m_run = 0, m_done = 0;

    stim_vec_seq dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cond_mask(cond_mask), .main_start(main_start), .last_addr(last_addr),
        .repeat_en(repeat_en), .start(start), .stop(stop), .ev_in(ev_in), .arm_in(arm_in),
        .vec_out(vec_out), .arm_out(arm_out), .running(running), .done(done)
    );

    always #10 clk = ~clk;

    // Reference model: advances once per rising edge from the same inputs.
    always @(posedge clk) begin
        bit go;
        logic [49:0] e;
        m_arm = 0;
        if (!rst_n) begin
            m_addr = 0; m_vec = '0; m_run = 0; m_done = 0;
        end else if (stop) begin
            m_run = 0; m_done = 0;
        end else if (!m_run) begin
            if (start) begin m_run = 1; m_done = 0; m_addr = 0; end
        end else begin
            e = mm[m_addr];
            go = 1;
            case (e[49:48])
                2'b00: m_vec = e[47:0];
                2'b10: m_arm = 1;
                2'b01: go = cond_mask[e[1:0]*8 + ev_in];
                default: go = arm_in;
            endcase
            if (go) begin
                if (m_addr == int'(last_addr)) begin
                    if (repeat_en) m_addr = int'(main_start);
                    else begin m_run = 0; m_done = 1; end
                end else m_addr = m_addr + 1;
            end
        end
    end

    // Count arm pulses as seen on the port before the edge updates it.
    always @(posedge clk) if (rst_n && arm_out) arm_cnt++;

    // Compare DUT with model every cycle, away from the edge.
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if ({vec_out, arm_out, running, done} !== {m_vec, m_arm, m_run, m_done}) begin
                errors++;
                $display("FAIL %s cycle %0d act=%h/%b%b%b exp=%h/%b%b%b", cur_tag, cyc,
                         vec_out, arm_out, running, done, m_vec, m_arm, m_run, m_done);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog act=%0d exp<=20000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input int a, input logic [1:0] k, input logic [47:0] p);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a[5:0]; wr_data = {k, p};
        mm[a] = {k, p};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mm[i] = '0;
        idle(3);
        // R1 reset values
        chk(vec_out == '0 && !arm_out && !running && !done, "R1 reset",
            {vec_out, arm_out, running, done}, 0);
        @(negedge clk); rst_n = 1'b1;

        // Program: preamble 0..1, main 2..6
        put(0, 2'b00, 48'h0000_0000_0111);
        put(1, 2'b10, 48'h0);
        put(2, 2'b00, 48'h0000_0000_0222);
        put(3, 2'b01, 48'h1);               // wait, condition 1
        put(4, 2'b00, 48'hABCD_0000_0333);
        put(5, 2'b11, 48'h0);               // wait for arm_in
        put(6, 2'b00, 48'h8000_0000_0444);
        cond_mask = 32'h0000_2000;          // condition 1 accepts ev_in==5 only
        main_start = 6'd2; last_addr = 6'd6;

        // Straight run, single mode, waits already satisfied
        cur_tag = "R3"; ev_in = 3'd5; arm_in = 1'b1; repeat_en = 1'b0;
        arm_cnt = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(running == 1'b1, "R2 running after start", running, 1);
        idle(10);
        chk(done && !running, "R8 done after last entry", {running, done}, 1);
        chk(vec_out == 48'h8000_0000_0444, "R3 last data vector", vec_out, 48'h8000_0000_0444);
        chk(arm_cnt == 1, "R4 one arm pulse", arm_cnt, 1);

        // Restart from done with waits blocking
        cur_tag = "R5"; ev_in = 3'd4; arm_in = 1'b0; arm_cnt = 0;
        pulse_start();
        chk(running && !done, "R11 restart clears done", {running, done}, 2);
        idle(8);
        chk(vec_out == 48'h222 && running, "R5 held at event wait (ev 4)", vec_out, 48'h222);
        chk(arm_cnt == 1, "R11 preamble arm replayed", arm_cnt, 1);
        ev_in = 3'd0; idle(4);
        chk(vec_out == 48'h222, "R5 held at event wait (ev 0)", vec_out, 48'h222);
        ev_in = 3'd5; idle(4);
        cur_tag = "R6"; ev_in = 3'd0;
        chk(vec_out == 48'hABCD_0000_0333 && running, "R6 held at arm wait",
            vec_out, 48'hABCD_0000_0333);
        idle(5);
        chk(running && !done, "R6 no advance without arm_in", {running, done}, 2);
        arm_in = 1'b1; @(negedge clk); arm_in = 1'b0;
        idle(3);
        chk(done && vec_out == 48'h8000_0000_0444, "R6 released by arm_in", vec_out,
            48'h8000_0000_0444);

        // Repetitive mode
        cur_tag = "R7"; ev_in = 3'd5; arm_in = 1'b1; repeat_en = 1'b1; arm_cnt = 0;
        pulse_start();
        idle(40);
        chk(running && !done, "R7 still running after passes", {running, done}, 2);
        chk(arm_cnt == 1, "R7 preamble not replayed", arm_cnt, 1);
        cur_tag = "R10";
        pulse_start(); idle(20);
        chk(arm_cnt == 1, "R10 start while running ignored", arm_cnt, 1);

        // Stop mid-run
        cur_tag = "R9";
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        chk(!running && !done, "R9 stop to idle", {running, done}, 0);
        idle(3);
        // Stop beats start
        @(negedge clk); stop = 1'b1; start = 1'b1;
        @(negedge clk); stop = 1'b0; start = 1'b0;
        chk(!running && !done, "R9 stop wins over start", {running, done}, 0);
        idle(3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule